// File: doc/BRIEF.md
# Hashed Individual Address Filter

This block decides whether an incoming Ethernet frame is addressed to this station. Given the frame's 48-bit destination address, it accepts the frame when the address equals the programmed station address. When it does not, the block looks the address up in a 64-bit hash table. The table is held as a lower and an upper 32-bit word. The hash is a reflected CRC-32 computed one address bit per clock. Addresses with the group (multicast) bit set are never handled here and are always reported as not matched.

A lookup starts with a one-cycle `start` pulse while the block is idle. The block captures the address, runs 48 CRC steps and then pulses `done`. `accept` and `hash_hit` hold their values until the next `done`. The station address is supplied in its register layout. The first word carries bytes 0..3, most significant byte first. The upper half of the second word carries bytes 4 and 5. The lower half of the second word carries a fixed type value (0x8808 by convention), and that value takes no part in matching.

Top module: `addr_hash_filter`

## Requirements
- R1: After reset `busy`, `done`, `accept` and `hash_hit` are all 0.
- R2: A `start` pulse is taken only while `busy` is 0. A `start` pulse while busy is ignored, so the result and its timing belong to the first address.
- R3: `done` is a single-cycle pulse that is high exactly 48 clock edges after the edge that took `start`. `busy` is high from the edge that takes `start` until that same edge.
- R4: The hash starts from 0xFFFFFFFF and takes address bytes 0 to 5 in turn, each least significant bit first. Byte 0 is `dst_addr[47:40]` and byte 5 is `dst_addr[7:0]`. At each bit the register shifts right by one. It is then XORed with 0xEDB88320 when the incoming bit differs from register bit 0.
- R5: The hash index is bits 31:26 of the final CRC. An index of 32 or more selects bit (index-32) of `hash_hi`. A smaller index selects bit (index) of `hash_lo`.
- R6: The station address is `{sta_word0, sta_word1[31:16]}`, with byte 0 in `sta_word0[31:24]`. `sta_word1[15:0]` holds the type value and is ignored when matching.
- R7: An exact station match gives `accept`=1 and `hash_hit`=0, whatever the table holds.
- R8: When byte 0 bit 0 (`dst_addr[40]`) is 1, the result is `accept`=0 and `hash_hit`=0, even if the address matches the station or hits the table.
- R9: With no exact match, the result is `accept`=`hash_hit`=(selected table bit).
- R10: `accept` and `hash_hit` change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup of `dst_addr` |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| sta_word0 | input | 32 | Station address bytes 0..3, MSB first |
| sta_word1 | input | 32 | Station bytes 4,5 in 31:16; type value in 15:0 |
| hash_lo | input | 32 | Hash table bits for indices 0..31 |
| hash_hi | input | 32 | Hash table bits for indices 32..63 |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Frame accepted (held) |
| hash_hit | output | 1 | Accepted through the hash table (held) |

## Verification
The bench picks addresses whose hash index falls in each half of the table. For each one it sets only the right bit, then only the same bit position in the wrong word, and then every bit except the right one. A wrong word select, a wrong CRC bit order or a wrong index slice shows up as a missed or a false accept. A station match is tried with an empty table and with an unrelated type value. This catches a design that wrongly compares the type half or routes the match through the table. A group address that also equals the station and sees a full table must be rejected. A second `start` is sent mid-lookup to catch a design that restarts. Exact `done` latency and result holding are checked on every lookup.

// File: rtl/ahf_pkg.sv
package ahf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_BITS  = 8 * ADDR_BYTES;
    localparam int CRC_W      = 32;
    localparam int IDX_W      = 6;
    localparam int CNT_W      = $clog2(ADDR_BITS);
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic                 accept;
        logic                 hash_hit;
        logic                 sta_eq;
        logic                 grp;
        logic [CNT_W-1:0]     cnt;
        logic [ADDR_BITS-1:0] sr;
        logic [CRC_W-1:0]     crc;
    } ahf_state_t;
endpackage

// File: rtl/ahf_bit_order.sv
module ahf_bit_order #(
    parameter int NBYTES = 6
) (
    input  logic [8*NBYTES-1:0] addr,
    output logic [8*NBYTES-1:0] serial
);
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        for (genvar j = 0; j < 8; j++) begin : g_bit
            assign serial[8*k+j] = addr[8*(NBYTES-1-k)+j];
        end
    end
endmodule

// File: rtl/ahf_crc_step.sv
module ahf_crc_step #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     POLY = 32'hEDB8_8320
) (
    input  logic         in_bit,
    input  logic [W-1:0] crc_in,
    output logic [W-1:0] crc_out
);
    always_comb begin
        crc_out = crc_in >> 1;
        if (in_bit ^ crc_in[0]) begin
            crc_out = crc_out ^ POLY;
        end
    end
endmodule

// File: rtl/ahf_hash_lookup.sv
module ahf_hash_lookup #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [2**(IDX_W-1)-1:0] tbl_lo,
    input  logic [2**(IDX_W-1)-1:0] tbl_hi,
    output logic                    bit_set
);
    localparam int SUB_W = IDX_W - 1;
    logic [SUB_W-1:0] pos;
    assign pos     = idx[SUB_W-1:0];
    assign bit_set = idx[IDX_W-1] ? tbl_hi[pos] : tbl_lo[pos];
endmodule

// File: rtl/ahf_station_cmp.sv
module ahf_station_cmp #(
    parameter int NBYTES = 6
) (
    input  logic [8*NBYTES-1:0] addr,
    input  logic [8*NBYTES-1:0] station,
    output logic                equal
);
    logic [NBYTES-1:0] byte_eq;
    for (genvar k = 0; k < NBYTES; k++) begin : g_cmp
        assign byte_eq[k] = (addr[8*k +: 8] == station[8*k +: 8]);
    end
    assign equal = &byte_eq;
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter
    import ahf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_BITS-1:0] dst_addr,
    input  logic [31:0]          sta_word0,
    input  logic [31:0]          sta_word1,
    input  logic [31:0]          hash_lo,
    input  logic [31:0]          hash_hi,
    output logic                 busy,
    output logic                 done,
    output logic                 accept,
    output logic                 hash_hit
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BITS - 1);

    ahf_state_t s_d, s_q;

    logic [ADDR_BITS-1:0] serial_addr;
    logic [ADDR_BITS-1:0] station;
    logic                 sta_equal;
    logic [CRC_W-1:0]     crc_nxt;
    logic                 tbl_bit;

    assign station = {sta_word0, sta_word1[31:16]};

    ahf_bit_order #(.NBYTES(ADDR_BYTES)) u_order (
        .addr   (dst_addr),
        .serial (serial_addr)
    );

    ahf_station_cmp #(.NBYTES(ADDR_BYTES)) u_cmp (
        .addr    (dst_addr),
        .station (station),
        .equal   (sta_equal)
    );

    ahf_crc_step #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .in_bit  (s_q.sr[0]),
        .crc_in  (s_q.crc),
        .crc_out (crc_nxt)
    );

    ahf_hash_lookup #(.IDX_W(IDX_W)) u_tbl (
        .idx     (crc_nxt[CRC_W-1 -: IDX_W]),
        .tbl_lo  (hash_lo),
        .tbl_hi  (hash_hi),
        .bit_set (tbl_bit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy   = 1'b1;
                s_d.cnt    = '0;
                s_d.crc    = CRC_INIT;
                s_d.sr     = serial_addr;
                s_d.sta_eq = sta_equal;
                s_d.grp    = serial_addr[0];
            end
        end else begin
            s_d.crc = crc_nxt;
            s_d.sr  = s_q.sr >> 1;
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST_CNT) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                if (s_q.grp) begin
                    s_d.accept   = 1'b0;
                    s_d.hash_hit = 1'b0;
                end else if (s_q.sta_eq) begin
                    s_d.accept   = 1'b1;
                    s_d.hash_hit = 1'b0;
                end else begin
                    s_d.accept   = tbl_bit;
                    s_d.hash_hit = tbl_bit;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign accept   = s_q.accept;
    assign hash_hit = s_q.hash_hit;
endmodule

// File: rtl/ahf_checker.sv
module ahf_checker
    import ahf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [ADDR_BITS-1:0] dst_addr,
    input logic                 busy,
    input logic                 done,
    input logic                 accept,
    input logic                 hash_hit
);
    localparam int LAT_W = $clog2(ADDR_BITS) + 2;

    logic [LAT_W-1:0] lat_cnt;
    logic             grp_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
            grp_cap <= 1'b0;
        end else if (start && !busy) begin
            lat_cnt <= '0;
            grp_cap <= dst_addr[ADDR_BITS-8];
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == LAT_W'(ADDR_BITS)));

    // R8
    group_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && grp_cap) |-> (!accept && !hash_hit));

    // R9
    hit_implies_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hash_hit) |-> accept);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(accept) && $stable(hash_hit)));
endmodule

bind addr_hash_filter ahf_checker u_ahf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dst_addr (dst_addr),
    .busy     (busy),
    .done     (done),
    .accept   (accept),
    .hash_hit (hash_hit)
);

// File: tb/sim_addr_hash_filter.sv
module sim_addr_hash_filter;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [31:0] sta_word0 = '0;
    logic [31:0] sta_word1 = '0;
    logic [31:0] hash_lo = '0;
    logic [31:0] hash_hi = '0;
    logic        busy, done, accept, hash_hit;

    int checks = 0;
    int errors = 0;

    addr_hash_filter u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr),
        .sta_word0(sta_word0), .sta_word1(sta_word1),
        .hash_lo(hash_lo), .hash_hi(hash_hi),
        .busy(busy), .done(done), .accept(accept), .hash_hit(hash_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) begin
                logic b;
                b = a[8*(5-k)+j];
                if (b ^ c[0]) c = (c >> 1) ^ 32'hEDB8_8320;
                else          c = c >> 1;
            end
        end
        return c[31:26];
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic lookup(input logic [47:0] a, input string tag, input logic exp_acc, input logic exp_hit);
        int cyc;
        @(negedge clk);
        dst_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(tag, "latency", cyc, LATENCY);
        check(tag, "accept", accept, exp_acc);
        check(tag, "hash_hit", hash_hit, exp_hit);
        @(negedge clk);
        check(tag, "done pulse width", done, 1'b0);
    endtask

    task automatic set_bit(input logic [5:0] idx);
        hash_lo = '0;
        hash_hi = '0;
        if (idx >= 32) hash_hi[idx-32] = 1'b1;
        else           hash_lo[idx[4:0]] = 1'b1;
    endtask

    task automatic t_reset;
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "accept", accept, 0);
        check("R1", "hash_hit", hash_hit, 0);
    endtask

    task automatic t_exact;
        sta_word0 = 32'h0222_3344;
        sta_word1 = 32'h5566_0000;
        hash_lo = '0; hash_hi = '0;
        lookup(48'h0222_3344_5566, "R7 R6", 1, 0);
        sta_word1 = 32'h5566_8808;
        lookup(48'h0222_3344_5566, "R6", 1, 0);
        lookup(48'h0222_3344_5567, "R9 miss", 0, 0);
    endtask

    task automatic t_hash(input logic want_hi);
        logic [47:0] a;
        logic [5:0]  ix;
        a = '0;
        for (int n = 0; n < 256; n++) begin
            a = {8'h0A, 8'h11, 8'h22, 8'h33, 8'h44, 8'(n)};
            ix = ref_idx(a);
            if (ix[5] == want_hi) break;
        end
        sta_word0 = 32'h0000_0000;
        sta_word1 = 32'h0000_8808;
        set_bit(ix);
        lookup(a, "R4 R5 hit", 1, 1);
        if (ix[5]) begin hash_hi = '0; hash_lo = '0; hash_lo[ix[4:0]] = 1'b1; end
        else       begin hash_lo = '0; hash_hi = '0; hash_hi[ix[4:0]] = 1'b1; end
        lookup(a, "R5 wrong word", 0, 0);
        set_bit(ix);
        hash_lo = ~hash_lo; hash_hi = ~hash_hi;
        lookup(a, "R9 all but one", 0, 0);
    endtask

    task automatic t_group;
        sta_word0 = 32'h0122_3344;
        sta_word1 = 32'h5566_8808;
        hash_lo = '1; hash_hi = '1;
        lookup(48'h0122_3344_5566, "R8", 0, 0);
    endtask

    task automatic t_busy_start;
        int cyc;
        logic [47:0] a;
        a = 48'h0200_0000_0001;
        sta_word0 = 32'h0200_0000;
        sta_word1 = 32'h0001_8808;
        hash_lo = '0; hash_hi = '0;
        @(negedge clk);
        dst_addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        check("R3", "busy after start", busy, 1);
        repeat (10) begin @(negedge clk); cyc++; end
        dst_addr = 48'h0200_0000_0099; start = 1'b1;
        @(negedge clk); cyc++;
        start = 1'b0;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        check("R2", "latency", cyc, LATENCY);
        check("R2", "accept first addr", accept, 1);
        @(negedge clk);
        check("R2", "busy after done", busy, 0);
    endtask

    task automatic t_hold;
        hash_lo = '1; hash_hi = '1;
        repeat (5) @(negedge clk);
        check("R10", "accept held", accept, 1);
        check("R10", "hash_hit held", hash_hit, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_exact();
        t_hash(1'b0);
        t_hash(1'b1);
        t_group();
        t_busy_start();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule